// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block holds recently used translations from virtual page number (VPN) to page table entry (PTE). Every stored tag is compared against the presented VPN at once, so a lookup answers hit or miss, the cached PTE, and the resulting physical address in the same cycle it is asked. After a miss, whoever walks the page tables installs the translation through the fill port. Two maintenance inputs keep the cache honest: one removes the single entry that carries a given VPN when that PTE is edited, and one wipes every entry at once when the running process changes.

Placement of a fill is steered by an occupancy state register with three states: `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_FULL`. A flush moves any state to `OCC_EMPTY`. A fill from `OCC_EMPTY` moves to `OCC_PARTIAL`. A fill that takes the last free slot moves `OCC_PARTIAL` to `OCC_FULL`. An invalidate that frees a slot moves `OCC_FULL` back to `OCC_PARTIAL`, and one that removes the last live entry moves `OCC_PARTIAL` to `OCC_EMPTY`. While not full, a new VPN lands in the lowest-numbered free slot. Once full, it replaces the least recently used entry. Recency is kept as a per-entry age that forms a permutation of 0..ENTRIES-1.

Top module: `tlb_fa`

## Requirements
- R1: With `lk_valid_i` high, `lk_hit_o` is 1 in the same cycle exactly when a valid entry's tag equals `lk_vpn_i`. `lk_pte_o` then carries that entry's PTE. On a miss, `lk_pte_o` and `lk_paddr_o` are zero.
- R2: On a hit, `lk_paddr_o` equals the PTE bits [PTE_W-1:OFF_W] (the frame number) concatenated above `lk_offset_i`.
- R3: While `lk_valid_i` is low, `lk_hit_o`, `lk_pte_o` and `lk_paddr_o` are zero, whatever `lk_vpn_i` holds.
- R4: The array holds ENTRIES distinct translations at once (default 16, intended range 16 to 48), and all of them hit.
- R5: With `inv_valid_i` high, the entry whose tag equals `inv_vpn_i` misses from the next cycle on. An invalidate of a VPN that is absent changes nothing.
- R6: `flush_i` makes every entry invalid, so every lookup misses from the next cycle on.
- R7: When `flush_i` and `fill_valid_i` are high in the same cycle, the flush wins and the filled VPN misses afterwards.
- R8: While any slot is free, a fill of a new VPN evicts no live translation.
- R9: When all slots are valid, a fill of a new VPN evicts the least recently used entry, and only that entry.
- R10: A lookup hit and a fill both make the touched entry the most recently used.
- R11: A fill whose VPN is already present overwrites that entry in place with the new PTE. It evicts nothing, and a VPN never matches more than one entry.
- R12: When a fill and an invalidate arrive in the same cycle, a matching VPN means the fill wins. Different VPNs mean both take effect, and the fill's slot is chosen from the state before the invalidate.
- R13: After reset, every entry is invalid and all lookups miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Virtual page number to translate |
| lk_offset_i | input | OFF_W | Page offset carried into the physical address |
| lk_hit_o | output | 1 | Lookup found a valid translation |
| lk_pte_o | output | PTE_W | Cached PTE on a hit, zero otherwise |
| lk_paddr_o | output | PTE_W | Frame number and offset on a hit, zero otherwise |
| fill_valid_i | input | 1 | Install a translation this cycle |
| fill_vpn_i | input | VPN_W | Tag of the translation to install |
| fill_pte_i | input | PTE_W | PTE to install |
| inv_valid_i | input | 1 | Invalidate one entry by VPN this cycle |
| inv_vpn_i | input | VPN_W | VPN to invalidate |
| flush_i | input | 1 | Clear every valid bit |

## Verification
Flush and fill can coincide in one cycle, and the flush must win. The bench provokes this by first installing one VPN and then, in a single cycle, raising `flush_i` together with a fill of a second VPN. It judges the outcome by looking up both VPNs afterwards: each must miss, with PTE and address outputs at zero. A bound property also demands that no lookup hits in the cycle after any flush. The related fill-with-invalidate coincidence is driven both with equal VPNs (the new PTE must be served) and with different VPNs (the invalidated one must miss while the filled one hits).

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Occupancy of the translation array, steering where a fill lands.
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

    // Maintenance action decoded for the current cycle.
    typedef enum logic [2:0] {
        MNT_IDLE       = 3'd0,
        MNT_FLUSH      = 3'd1,
        MNT_FILL       = 3'd2,
        MNT_INVAL      = 3'd3,
        MNT_FILL_INVAL = 3'd4
    } mnt_e;

endpackage

// File: rtl/tlb_cam.sv
// Parallel tag compare: one match bit per entry, gated by its valid bit.
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20
) (
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags_i,
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [VPN_W-1:0]              key_i,
    output logic [ENTRIES-1:0]            match_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
    end
endmodule

// File: rtl/tlb_enc.sv
// One-hot to binary index; an all-zero input yields index zero.
module tlb_enc #(
    parameter int ENTRIES = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] oh_i,
    output logic [IW-1:0]      idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (oh_i[i]) begin
                idx_o = idx_o | IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_lru.sv
// True LRU by per-entry ages. Ages stay a permutation of 0..ENTRIES-1.
// Age 0 is most recent, age ENTRIES-1 is the victim.
module tlb_lru #(
    parameter int ENTRIES = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               touch_a_en_i,
    input  logic [IW-1:0]      touch_a_idx_i,
    input  logic               touch_b_en_i,
    input  logic [IW-1:0]      touch_b_idx_i,
    output logic [ENTRIES-1:0] victim_oh_o
);
    typedef logic [ENTRIES-1:0][IW-1:0] age_t;

    age_t age_q, age_d;

    function automatic age_t promote(input age_t a, input logic [IW-1:0] k);
        age_t r;
        r = a;
        for (int i = 0; i < ENTRIES; i++) begin
            if (a[i] < a[k]) begin
                r[i] = a[i] + 1'b1;
            end
        end
        r[k] = '0;
        return r;
    endfunction

    always_comb begin
        age_d = age_q;
        if (touch_a_en_i) begin
            age_d = promote(age_d, touch_a_idx_i);
        end
        if (touch_b_en_i) begin
            age_d = promote(age_d, touch_b_idx_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < ENTRIES; i++) begin
                age_q[i] <= IW'(i);
            end
        end else begin
            age_q <= age_d;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vic
        assign victim_oh_o[g] = (age_q[g] == IW'(ENTRIES - 1));
    end
endmodule

// File: rtl/tlb_alloc.sv
// Chooses the slot for a new VPN: lowest free slot, or the LRU victim when full.
module tlb_alloc
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  occ_e               occ_i,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [IW-1:0]      victim_idx_i,
    output logic [IW-1:0]      slot_o
);
    logic [IW-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_idx = IW'(i);
            end
        end
    end

    always_comb begin
        unique case (occ_i)
            OCC_EMPTY:   slot_o = '0;
            OCC_PARTIAL: slot_o = free_idx;
            OCC_FULL:    slot_o = victim_idx_i;
            default:     slot_o = victim_idx_i;
        endcase
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int PTE_W   = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lk_valid_i,
    input  logic [VPN_W-1:0] lk_vpn_i,
    input  logic [OFF_W-1:0] lk_offset_i,
    output logic             lk_hit_o,
    output logic [PTE_W-1:0] lk_pte_o,
    output logic [PTE_W-1:0] lk_paddr_o,
    input  logic             fill_valid_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PTE_W-1:0] fill_pte_i,
    input  logic             inv_valid_i,
    input  logic [VPN_W-1:0] inv_vpn_i,
    input  logic             flush_i
);
    localparam int IW    = $clog2(ENTRIES);
    localparam int PFN_W = PTE_W - OFF_W;

    // Storage
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PTE_W-1:0] pte_q;
    logic [ENTRIES-1:0]            valid_q, valid_d;
    occ_e                          occ_q, occ_d;

    // Compare and select
    logic [ENTRIES-1:0] lk_match, fill_match, inv_match, fill_sel;
    logic [ENTRIES-1:0] lru_victim_oh;
    logic [IW-1:0]      lk_idx, fill_hit_idx, victim_idx, alloc_idx, fill_slot;
    logic               fill_we;
    mnt_e               mnt;

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_lk (
        .tags_i(vpn_q), .valid_i(valid_q), .key_i(lk_vpn_i), .match_o(lk_match)
    );
    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_fill (
        .tags_i(vpn_q), .valid_i(valid_q), .key_i(fill_vpn_i), .match_o(fill_match)
    );
    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_inv (
        .tags_i(vpn_q), .valid_i(valid_q), .key_i(inv_vpn_i), .match_o(inv_match)
    );

    tlb_enc #(.ENTRIES(ENTRIES)) u_enc_lk   (.oh_i(lk_match),      .idx_o(lk_idx));
    tlb_enc #(.ENTRIES(ENTRIES)) u_enc_fill (.oh_i(fill_match),    .idx_o(fill_hit_idx));
    tlb_enc #(.ENTRIES(ENTRIES)) u_enc_vic  (.oh_i(lru_victim_oh), .idx_o(victim_idx));

    tlb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .occ_i       (occ_q),
        .valid_i     (valid_q),
        .victim_idx_i(victim_idx),
        .slot_o      (alloc_idx)
    );

    // Maintenance decode: flush dominates every other action.
    always_comb begin
        if (flush_i)                         mnt = MNT_FLUSH;
        else if (fill_valid_i && inv_valid_i) mnt = MNT_FILL_INVAL;
        else if (fill_valid_i)               mnt = MNT_FILL;
        else if (inv_valid_i)                mnt = MNT_INVAL;
        else                                 mnt = MNT_IDLE;
    end

    assign fill_we   = (mnt == MNT_FILL) || (mnt == MNT_FILL_INVAL);
    assign fill_slot = (|fill_match) ? fill_hit_idx : alloc_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
        assign fill_sel[g] = fill_we && (fill_slot == IW'(g));
    end

    // Next valid vector; a filled slot overrides an invalidate of its old tag.
    always_comb begin
        unique case (mnt)
            MNT_FLUSH:      valid_d = '0;
            MNT_FILL:       valid_d = valid_q | fill_sel;
            MNT_INVAL:      valid_d = valid_q & ~inv_match;
            MNT_FILL_INVAL: valid_d = (valid_q & ~inv_match) | fill_sel;
            MNT_IDLE:       valid_d = valid_q;
            default:        valid_d = valid_q;
        endcase
    end

    // Occupancy next state
    always_comb begin
        if (valid_d == '0)   occ_d = OCC_EMPTY;
        else if (&valid_d)   occ_d = OCC_FULL;
        else                 occ_d = OCC_PARTIAL;
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            occ_q   <= OCC_EMPTY;
            valid_q <= '0;
        end else begin
            occ_q   <= occ_d;
            valid_q <= valid_d;
        end
    end

    // Tag and PTE storage (no reset needed; guarded by valid bits)
    always_ff @(posedge clk_i) begin
        if (fill_we) begin
            vpn_q[fill_slot] <= fill_vpn_i;
            pte_q[fill_slot] <= fill_pte_i;
        end
    end

    // Recency: lookup hit first, then the fill, so a fill ends up newest.
    tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .touch_a_en_i (lk_hit_o),
        .touch_a_idx_i(lk_idx),
        .touch_b_en_i (fill_we),
        .touch_b_idx_i(fill_slot),
        .victim_oh_o  (lru_victim_oh)
    );

    // Lookup outputs
    always_comb begin
        logic [PTE_W-1:0] pte_sel;
        pte_sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                pte_sel = pte_sel | pte_q[i];
            end
        end
        lk_hit_o = lk_valid_i && (|lk_match);
        if (lk_hit_o) begin
            lk_pte_o   = pte_sel;
            lk_paddr_o = {pte_sel[PTE_W-1 -: PFN_W], lk_offset_i};
        end else begin
            lk_pte_o   = '0;
            lk_paddr_o = '0;
        end
    end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PTE_W   = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               lk_valid_i,
    input logic [VPN_W-1:0]   lk_vpn_i,
    input logic               lk_hit_o,
    input logic [PTE_W-1:0]   lk_pte_o,
    input logic               fill_valid_i,
    input logic [VPN_W-1:0]   fill_vpn_i,
    input logic [PTE_W-1:0]   fill_pte_i,
    input logic               inv_valid_i,
    input logic [VPN_W-1:0]   inv_vpn_i,
    input logic               flush_i,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] victim_oh
);
    a_r3_idle_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_valid_i |-> !lk_hit_o);

    a_r6_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !lk_hit_o);

    a_r5_inval_gone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inv_valid_i && !(fill_valid_i && fill_vpn_i == inv_vpn_i))
        |=> !(lk_valid_i && lk_vpn_i == $past(inv_vpn_i) && lk_hit_o));

    a_r1_fill_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_valid_i && !flush_i)
        |=> (!(lk_valid_i && lk_vpn_i == $past(fill_vpn_i))
             || (lk_hit_o && lk_pte_o == $past(fill_pte_i))));

    a_r11_unique_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(lk_match));

    a_r9_single_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(victim_oh) == 1);
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PTE_W(PTE_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_valid_i  (lk_valid_i),
    .lk_vpn_i    (lk_vpn_i),
    .lk_hit_o    (lk_hit_o),
    .lk_pte_o    (lk_pte_o),
    .fill_valid_i(fill_valid_i),
    .fill_vpn_i  (fill_vpn_i),
    .fill_pte_i  (fill_pte_i),
    .inv_valid_i (inv_valid_i),
    .inv_vpn_i   (inv_vpn_i),
    .flush_i     (flush_i),
    .lk_match    (lk_match),
    .victim_oh   (lru_victim_oh)
);

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [19:0] lk_vpn;
    logic [11:0] lk_off;
    logic        lk_hit;
    logic [31:0] lk_pte;
    logic [31:0] lk_paddr;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [31:0] fill_pte;
    logic        inv_valid;
    logic [19:0] inv_vpn;
    logic        flush;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    tlb_fa u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn), .lk_offset_i(lk_off),
        .lk_hit_o(lk_hit), .lk_pte_o(lk_pte), .lk_paddr_o(lk_paddr),
        .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_pte_i(fill_pte),
        .inv_valid_i(inv_valid), .inv_vpn_i(inv_vpn), .flush_i(flush)
    );

    // Reference model: list ordered least to most recently used.
    typedef struct { logic [19:0] vpn; logic [31:0] pte; } ent_t;
    ent_t mq[$];

    function automatic int m_find(input logic [19:0] vpn);
        foreach (mq[i]) if (mq[i].vpn == vpn) return i;
        return -1;
    endfunction

    function automatic void m_touch(input int k);
        ent_t e;
        e = mq[k];
        mq.delete(k);
        mq.push_back(e);
    endfunction

    function automatic void m_fill(input logic [19:0] vpn, input logic [31:0] pte);
        int k;
        ent_t e;
        k = m_find(vpn);
        if (k >= 0) mq.delete(k);
        else if (mq.size() == N) void'(mq.pop_front());
        e.vpn = vpn;
        e.pte = pte;
        mq.push_back(e);
    endfunction

    function automatic logic [31:0] mkpte(input logic [19:0] vpn, input logic [3:0] ver);
        return {(vpn ^ 20'h5A5A5) + {16'h0, ver}, 8'h0F, ver};
    endfunction

    function automatic void chk(input string req, input string what,
                                input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    task automatic idle_drive();
        lk_valid = 1'b0; lk_vpn = '0; lk_off = '0;
        fill_valid = 1'b0; fill_vpn = '0; fill_pte = '0;
        inv_valid = 1'b0; inv_vpn = '0; flush = 1'b0;
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] off, input string req);
        int k;
        logic eh;
        logic [31:0] ep;
        @(negedge clk);
        idle_drive();
        lk_valid = 1'b1; lk_vpn = vpn; lk_off = off;
        #1;
        k  = m_find(vpn);
        eh = (k >= 0);
        ep = eh ? mq[k].pte : 32'h0;
        chk(req, "hit", 64'(lk_hit), 64'(eh));
        chk(req, "pte", 64'(lk_pte), 64'(ep));
        chk(req, "paddr", 64'(lk_paddr), eh ? 64'({ep[31:12], off}) : 64'h0);
        @(posedge clk);
        if (eh) m_touch(k);
    endtask

    task automatic look_all(input string req);
        ent_t snap[$];
        snap = mq;
        foreach (snap[i]) look(snap[i].vpn, 12'(i * 37), req);
    endtask

    task automatic maint(input logic fv, input logic [19:0] fvpn, input logic [31:0] fpte,
                         input logic iv, input logic [19:0] ivpn, input logic fl);
        int k;
        @(negedge clk);
        idle_drive();
        fill_valid = fv; fill_vpn = fvpn; fill_pte = fpte;
        inv_valid = iv; inv_vpn = ivpn; flush = fl;
        @(posedge clk);
        if (fl) mq.delete();
        else begin
            if (fv) m_fill(fvpn, fpte);
            if (iv && !(fv && fvpn == ivpn)) begin
                k = m_find(ivpn);
                if (k >= 0) mq.delete(k);
            end
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [31:0] pte);
        maint(1'b1, vpn, pte, 1'b0, '0, 1'b0);
    endtask

    task automatic t_reset();
        look(20'h00001, 12'h010, "R13");
        look(20'h00000, 12'h000, "R13");
        look(20'hFFFFF, 12'hFFF, "R13");
    endtask

    task automatic t_basic();
        fill(20'h12345, 32'hABCDE3F1);
        look(20'h12345, 12'hABC, "R1 R2");
        look(20'h12346, 12'hABC, "R1");
        @(negedge clk);
        idle_drive();
        lk_vpn = 20'h12345; lk_off = 12'h111;
        #1;
        chk("R3", "hit", 64'(lk_hit), 64'h0);
        chk("R3", "pte", 64'(lk_pte), 64'h0);
        chk("R3", "paddr", 64'(lk_paddr), 64'h0);
        @(posedge clk);
    endtask

    task automatic t_capacity();
        maint(1'b0, '0, '0, 1'b0, '0, 1'b1);
        for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), mkpte(20'h00100 + 20'(i), 4'h1));
        look_all("R4");
        chk("R4", "model size", 64'(mq.size()), 64'(N));
        maint(1'b0, '0, '0, 1'b1, 20'h00103, 1'b0);
        maint(1'b0, '0, '0, 1'b1, 20'h0010A, 1'b0);
        look(20'h00103, 12'h5, "R5");
        fill(20'h00200, mkpte(20'h00200, 4'h2));
        fill(20'h00201, mkpte(20'h00201, 4'h2));
        look_all("R8");
        chk("R8", "model size", 64'(mq.size()), 64'(N));
    endtask

    task automatic t_lru();
        maint(1'b0, '0, '0, 1'b0, '0, 1'b1);
        for (int i = 0; i < N; i++) fill(20'h00300 + 20'(i), mkpte(20'h00300 + 20'(i), 4'h3));
        look(20'h00300, 12'h1, "R10");           // 0x300 becomes newest, 0x301 oldest
        fill(20'h003F0, mkpte(20'h003F0, 4'h3));
        look(20'h00301, 12'h2, "R9");            // evicted
        look(20'h00300, 12'h3, "R9 R10");
        look(20'h003F0, 12'h4, "R9");
        fill(20'h00302, mkpte(20'h00302, 4'h4)); // refill makes 0x302 newest
        fill(20'h003F1, mkpte(20'h003F1, 4'h3)); // evicts 0x303
        look(20'h00303, 12'h5, "R10");
        look(20'h00302, 12'h6, "R10");
        look_all("R9");
    endtask

    task automatic t_overwrite();
        fill(20'h00305, mkpte(20'h00305, 4'h9));
        look(20'h00305, 12'h7, "R11");
        chk("R11", "model size", 64'(mq.size()), 64'(N));
        look_all("R11");
    endtask

    task automatic t_inval();
        maint(1'b0, '0, '0, 1'b1, 20'h00306, 1'b0);
        look(20'h00306, 12'h8, "R5");
        maint(1'b0, '0, '0, 1'b1, 20'h00999, 1'b0);
        look_all("R5");
    endtask

    task automatic t_flush();
        maint(1'b0, '0, '0, 1'b0, '0, 1'b1);
        look(20'h00300, 12'h9, "R6");
        look(20'h003F0, 12'h9, "R6");
        fill(20'h00400, mkpte(20'h00400, 4'h5));
        look(20'h00400, 12'hA, "R7");
        maint(1'b1, 20'h00401, mkpte(20'h00401, 4'h5), 1'b0, '0, 1'b1);
        look(20'h00400, 12'hB, "R7");
        look(20'h00401, 12'hC, "R7");
    endtask

    task automatic t_fill_inval();
        fill(20'h00500, mkpte(20'h00500, 4'h6));
        fill(20'h00501, mkpte(20'h00501, 4'h6));
        maint(1'b1, 20'h00500, mkpte(20'h00500, 4'h7), 1'b1, 20'h00500, 1'b0);
        look(20'h00500, 12'hD, "R12");
        maint(1'b1, 20'h00502, mkpte(20'h00502, 4'h7), 1'b1, 20'h00501, 1'b0);
        look(20'h00501, 12'hE, "R12");
        look(20'h00502, 12'hF, "R12");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle_drive();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_capacity();
        t_lru();
        t_overwrite();
        t_inval();
        t_flush();
        t_fill_inval();
        @(negedge clk);
        idle_drive();
        finish_run();
    end
endmodule